// File: doc/BRIEF.md
# Boot Unlock Controller

This block guards entry into a loader mode on a simple register bus. Software unlocks the mode by writing a fixed, ordered series of key bytes to a single trigger register. When the last byte of the key lands, the block enters boot mode. In boot mode it holds the application logic disabled and gives bus ownership to the loader.

A read-only identification register returns a fixed four-character ASCII code, so software can confirm which board it is talking to before it goes on. Setting the exit bit in the control register leaves boot mode and returns the bus to the application.

The key bytes, the register addresses, the identification word, the exit bit position and the read-port latency are all parameters.

Top module: `boot_unlock_ctrl`

## Requirements
- R1: After reset, or after a reset in the middle of a key, the block is in application mode: `boot_mode`, `app_disable` and `loader_grant` are 0, `bus_rdata` is 0, and the key progress is zero. Key bytes written before the reset do not count toward an unlock.
- R2: With the default key, eight writes to the trigger register (address 0) carry the byte values DE, AD, BE, EF, CA, FE, BA, BE in that order. `boot_mode` goes to 1 on the clock edge that takes the eighth write. It stays 0 after only seven of them.
- R3: `app_disable` and `loader_grant` are 1 exactly when the block is in boot mode, and 0 in application mode.
- R4: A trigger write whose byte is not the next expected key byte sets the progress back to zero. If that byte equals the first key byte (DE), it counts as the first byte of a new key.
- R5: Only bits 7:0 of a trigger write are compared with the key. Bits 31:8 have no effect on matching.
- R6: Writes to any address other than the trigger register, and all reads, leave the key progress unchanged.
- R7: A read of the identification register (address 2) returns 0x53564543, with the first character in bits 31:24 and the last in bits 7:0. With the default registered read port, the word appears on `bus_rdata` in the cycle after the read request.
- R8: A write to the control register (address 1) with bit 0 set ends boot mode on that clock edge. A control write with bit 0 clear, or any control write in application mode, leaves the mode unchanged.
- R9: A cycle with no read of the identification register yields `bus_rdata` equal to 0 in the following cycle.
- R10: `boot_mode` changes only on a completed key or an exit write. All other bus activity leaves it stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_re | input | 1 | Read strobe for one cycle |
| bus_addr | input | AW (4) | Register address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data |
| boot_mode | output | 1 | 1 while the loader mode is active |
| app_disable | output | 1 | Holds the application logic disabled |
| loader_grant | output | 1 | Gives bus ownership to the loader |

## Verification
The bench builds the block with its defaults: an eight-byte key, a 32-bit data bus, a 4-bit address and the registered read port. This setting brings the full-length key into reach, along with a restart on the first key byte partway through a key, upper-bit noise on trigger writes, and interleaved traffic to other addresses and to the identification register between key bytes. The one-cycle read latency is covered as well. A reset in the middle of a key shows that partial progress is discarded, and repeated exits show that an exit in application mode has no effect.

// File: rtl/boot_unlock_pkg.sv
package boot_unlock_pkg;
   localparam int unsigned KEY_BYTE_W = 8;
   typedef logic [KEY_BYTE_W-1:0] key_byte_t;
endpackage

// File: rtl/bul_key_matcher.sv
module bul_key_matcher
   import boot_unlock_pkg::*;
#(
   parameter int unsigned KEY_LEN = 8,
   parameter logic [KEY_LEN*KEY_BYTE_W-1:0] KEY = 64'hDEAD_BEEF_CAFE_BABE
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_hit,
   input  key_byte_t wr_byte,
   output logic      key_done
);
   localparam int unsigned PW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
   localparam logic [PW-1:0] LAST_IDX = PW'(KEY_LEN - 1);
   localparam logic [PW-1:0] SECOND_IDX = PW'(1);

   if (KEY_LEN < 2) begin : g_bad_len
      $error("bul_key_matcher: KEY_LEN must be at least 2");
   end

   key_byte_t key_arr [KEY_LEN];

   for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
      assign key_arr[g] = KEY[(KEY_LEN-1-g)*KEY_BYTE_W +: KEY_BYTE_W];
   end

   logic [PW-1:0] prog_q, prog_d;

   always_comb begin
      prog_d   = prog_q;
      key_done = 1'b0;
      if (wr_hit) begin
         if (wr_byte == key_arr[prog_q]) begin
            if (prog_q == LAST_IDX) begin
               prog_d   = '0;
               key_done = 1'b1;
            end else begin
               prog_d = prog_q + 1'b1;
            end
         end else if (wr_byte == key_arr[0]) begin
            prog_d = SECOND_IDX;
         end else begin
            prog_d = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prog_q <= '0;
      else        prog_q <= prog_d;
   end
endmodule

// File: rtl/bul_mode_reg.sv
module bul_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic enter,
   input  logic leave,
   output logic mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode <= 1'b0;
      else if (enter) mode <= 1'b1;
      else if (leave) mode <= 1'b0;
   end
endmodule

// File: rtl/bul_id_port.sv
module bul_id_port #(
   parameter int unsigned AW = 4,
   parameter int unsigned DW = 32,
   parameter logic [AW-1:0] ID_ADDR = 4'd2,
   parameter logic [DW-1:0] ID_CODE = 32'h5356_4543,
   parameter bit RD_REGISTERED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   logic          id_sel;
   logic [DW-1:0] rd_next;

   assign id_sel  = rd_en && (rd_addr == ID_ADDR);
   assign rd_next = id_sel ? ID_CODE : '0;

   if (RD_REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_next;
      end
   end else begin : g_comb
      assign rd_data = rd_next;
   end
endmodule

// File: rtl/boot_unlock_ctrl.sv
module boot_unlock_ctrl
   import boot_unlock_pkg::*;
#(
   parameter int unsigned AW = 4,
   parameter int unsigned DW = 32,
   parameter int unsigned KEY_LEN = 8,
   parameter logic [KEY_LEN*KEY_BYTE_W-1:0] KEY = 64'hDEAD_BEEF_CAFE_BABE,
   parameter logic [AW-1:0] TRIG_ADDR = 4'd0,
   parameter logic [AW-1:0] CTRL_ADDR = 4'd1,
   parameter logic [AW-1:0] ID_ADDR = 4'd2,
   parameter int unsigned EXIT_BIT = 0,
   parameter logic [DW-1:0] ID_CODE = 32'h5356_4543,
   parameter bit RD_REGISTERED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic          bus_re,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          boot_mode,
   output logic          app_disable,
   output logic          loader_grant
);
   if (DW < KEY_BYTE_W) begin : g_bad_dw
      $error("boot_unlock_ctrl: DW must hold one key byte");
   end
   if (EXIT_BIT >= DW) begin : g_bad_exit
      $error("boot_unlock_ctrl: EXIT_BIT outside the data word");
   end
   if (TRIG_ADDR == CTRL_ADDR || TRIG_ADDR == ID_ADDR || CTRL_ADDR == ID_ADDR) begin : g_bad_map
      $error("boot_unlock_ctrl: register addresses must differ");
   end

   logic trig_wr, exit_wr, key_done, mode_q;
   logic unused_wdata;

   assign trig_wr      = bus_we && (bus_addr == TRIG_ADDR);
   assign exit_wr      = bus_we && (bus_addr == CTRL_ADDR) && bus_wdata[EXIT_BIT];
   assign unused_wdata = ^bus_wdata;

   bul_key_matcher #(.KEY_LEN(KEY_LEN), .KEY(KEY)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (trig_wr),
      .wr_byte  (bus_wdata[KEY_BYTE_W-1:0]),
      .key_done (key_done)
   );

   bul_mode_reg u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .enter (key_done),
      .leave (exit_wr),
      .mode  (mode_q)
   );

   bul_id_port #(
      .AW(AW), .DW(DW), .ID_ADDR(ID_ADDR), .ID_CODE(ID_CODE),
      .RD_REGISTERED(RD_REGISTERED)
   ) u_id (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (bus_re),
      .rd_addr (bus_addr),
      .rd_data (bus_rdata)
   );

   assign boot_mode    = mode_q;
   assign app_disable  = mode_q;
   assign loader_grant = mode_q;
endmodule

// File: rtl/bul_checker.sv
module bul_checker #(
   parameter int unsigned AW = 4,
   parameter int unsigned DW = 32,
   parameter int unsigned KEY_LEN = 8,
   parameter logic [KEY_LEN*8-1:0] KEY = 64'hDEAD_BEEF_CAFE_BABE,
   parameter logic [AW-1:0] TRIG_ADDR = 4'd0,
   parameter logic [AW-1:0] CTRL_ADDR = 4'd1,
   parameter logic [AW-1:0] ID_ADDR = 4'd2,
   parameter int unsigned EXIT_BIT = 0,
   parameter logic [DW-1:0] ID_CODE = 32'h5356_4543,
   parameter bit RD_REGISTERED = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_we,
   input logic          bus_re,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic [DW-1:0] bus_rdata,
   input logic          boot_mode,
   input logic          app_disable,
   input logic          loader_grant
);
   a_r2_entry_on_last_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boot_mode) |-> $past(bus_we && bus_addr == TRIG_ADDR && bus_wdata[7:0] == KEY[7:0]));

   a_r8_exit_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == CTRL_ADDR && bus_wdata[EXIT_BIT]) |=> !boot_mode);

   a_r10_mode_stable_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && (bus_addr == TRIG_ADDR || bus_addr == CTRL_ADDR)) |=> $stable(boot_mode));

   a_r3_outputs_follow_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boot_mode) |-> (app_disable && loader_grant));

   if (RD_REGISTERED) begin : g_rd_reg
      a_r7_id_readback: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_re && bus_addr == ID_ADDR) |=> (bus_rdata == ID_CODE));
      a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !(bus_re && bus_addr == ID_ADDR) |=> (bus_rdata == '0));
   end else begin : g_rd_comb
      a_r7_id_readback: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_re && bus_addr == ID_ADDR) |-> (bus_rdata == ID_CODE));
      a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !(bus_re && bus_addr == ID_ADDR) |-> (bus_rdata == '0));
   end
endmodule

bind boot_unlock_ctrl bul_checker #(
   .AW(AW), .DW(DW), .KEY_LEN(KEY_LEN), .KEY(KEY),
   .TRIG_ADDR(TRIG_ADDR), .CTRL_ADDR(CTRL_ADDR), .ID_ADDR(ID_ADDR),
   .EXIT_BIT(EXIT_BIT), .ID_CODE(ID_CODE), .RD_REGISTERED(RD_REGISTERED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .boot_mode(boot_mode), .app_disable(app_disable), .loader_grant(loader_grant)
);

// File: tb/tb_boot_unlock_ctrl.sv
`timescale 1ns/100ps
module tb_boot_unlock_ctrl;
   localparam logic [3:0]  A_TRIG  = 4'd0;
   localparam logic [3:0]  A_CTRL  = 4'd1;
   localparam logic [3:0]  A_ID    = 4'd2;
   localparam logic [31:0] ID_WORD = 32'h5356_4543;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        boot_mode, app_disable, loader_grant;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int unsigned key_q[$] = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hCA, 8'hFE, 8'hBA, 8'hBE};

   // behavioural reference
   int          m_prog = 0;
   bit          m_mode = 1'b0;
   logic [31:0] m_rd   = '0;

   always #2.5 clk = ~clk;

   boot_unlock_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .boot_mode(boot_mode), .app_disable(app_disable), .loader_grant(loader_grant)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_prog = 0; m_mode = 1'b0; m_rd = '0;
      end else begin
         if (bus_we && bus_addr == A_TRIG) begin
            if (int'(bus_wdata[7:0]) == key_q[m_prog]) begin
               if (m_prog == key_q.size() - 1) begin
                  m_mode = 1'b1; m_prog = 0;
               end else m_prog++;
            end else m_prog = (int'(bus_wdata[7:0]) == key_q[0]) ? 1 : 0;
         end
         if (bus_we && bus_addr == A_CTRL && bus_wdata[0]) m_mode = 1'b0;
         m_rd = (bus_re && bus_addr == A_ID) ? ID_WORD : '0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R10 mode vs model", {31'd0, boot_mode}, {31'd0, m_mode});
         chk("R3 disable vs model", {31'd0, app_disable}, {31'd0, m_mode});
         chk("R3 grant vs model", {31'd0, loader_grant}, {31'd0, m_mode});
         chk("R9 rdata vs model", bus_rdata, m_rd);
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_we = 1'b1; bus_re = 1'b0; bus_addr = a; bus_wdata = d;
   endtask

   task automatic rd(input logic [3:0] a);
      @(posedge clk); #1;
      bus_we = 1'b0; bus_re = 1'b1; bus_addr = a; bus_wdata = '0;
   endtask

   task automatic idle();
      @(posedge clk); #1;
      bus_we = 1'b0; bus_re = 1'b0;
   endtask

   task automatic send_key(input logic [31:0] hi);
      foreach (key_q[i]) wr(A_TRIG, hi | key_q[i]);
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      bus_we = 1'b0; bus_re = 1'b0; rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic exit_boot();
      wr(A_CTRL, 32'h1); idle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset mode", {31'd0, boot_mode}, 32'd0);
      chk("R1 reset disable", {31'd0, app_disable}, 32'd0);
      chk("R1 reset rdata", bus_rdata, 32'd0);
      rst_n = 1'b1;

      // R2: seven bytes do not unlock, the eighth does
      for (int i = 0; i < 7; i++) wr(A_TRIG, key_q[i]);
      idle();
      chk("R2 seven bytes", {31'd0, boot_mode}, 32'd0);
      wr(A_TRIG, key_q[7]); idle();
      chk("R2 full key", {31'd0, boot_mode}, 32'd1);
      chk("R3 disable in boot", {31'd0, app_disable}, 32'd1);
      chk("R3 grant in boot", {31'd0, loader_grant}, 32'd1);

      // R7 / R9: identification read and other reads
      rd(A_ID); idle();
      chk("R7 id word", bus_rdata, ID_WORD);
      rd(4'd5); idle();
      chk("R9 other read", bus_rdata, 32'd0);

      // R8: exit handling
      wr(A_CTRL, 32'h2); idle();
      chk("R8 no exit bit", {31'd0, boot_mode}, 32'd1);
      exit_boot();
      chk("R8 exit", {31'd0, boot_mode}, 32'd0);
      chk("R3 disable after exit", {31'd0, app_disable}, 32'd0);
      exit_boot();
      chk("R8 exit in app", {31'd0, boot_mode}, 32'd0);

      // R4: wrong byte resets; first key byte restarts
      wr(A_TRIG, 8'hDE); wr(A_TRIG, 8'hAD); wr(A_TRIG, 8'hBE); wr(A_TRIG, 8'h11);
      for (int i = 3; i < 8; i++) wr(A_TRIG, key_q[i]);
      idle();
      chk("R4 broken key", {31'd0, boot_mode}, 32'd0);
      wr(A_TRIG, 8'hDE); wr(A_TRIG, 8'hAD);
      send_key(32'h0); idle();
      chk("R4 restart on first byte", {31'd0, boot_mode}, 32'd1);
      exit_boot();

      // R5: upper bits ignored
      send_key(32'hA5A5_5A00); idle();
      chk("R5 upper bits", {31'd0, boot_mode}, 32'd1);
      exit_boot();

      // R6: other traffic between key bytes
      for (int i = 0; i < 4; i++) wr(A_TRIG, key_q[i]);
      wr(4'd7, 32'h0000_00FF); wr(A_ID, 32'h0); rd(A_ID); rd(A_TRIG);
      for (int i = 4; i < 8; i++) wr(A_TRIG, key_q[i]);
      idle();
      chk("R6 interleaved", {31'd0, boot_mode}, 32'd1);
      exit_boot();

      // R1: reset in the middle discards progress
      for (int i = 0; i < 4; i++) wr(A_TRIG, key_q[i]);
      do_reset();
      for (int i = 4; i < 8; i++) wr(A_TRIG, key_q[i]);
      idle();
      chk("R1 mid-key reset", {31'd0, boot_mode}, 32'd0);
      send_key(32'h0); idle();
      chk("R1 key after reset", {31'd0, boot_mode}, 32'd1);
      exit_boot();
      repeat (2) idle();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule